// File: doc/BRIEF.md
# Reference Clock Output Divider

This block produces the buffered reference clock that leaves the tuner for neighbouring tuners and demodulators. It divides the crystal reference clock by a ratio taken from a 3-bit select field. The output stays at a 50% duty cycle for every ratio, odd ratios included. For odd ratios the block widens the high phase by half an input period with a copy retimed on the falling edge. The select field is written through the device's register interface. The block keeps running while the rest of the device is in standby.

The core is a small state machine clocked by the reference. There are three one-hot states. `ST_BYPASS` passes the input clock straight through for ratio 1. `ST_HIGH` drives the high phase of a divided period. `ST_LOW` drives its low phase. The transitions are:

- **enter-bypass**: at a period boundary, when the select decodes to ratio 1, the machine goes to `ST_BYPASS`.
- **start-period**: at a period boundary, when the select decodes to a ratio of 2 or more, the machine goes to `ST_HIGH`.
- **end-high**: once the high phase has lasted its count, `ST_HIGH` moves to `ST_LOW`.
- **hold-low**: `ST_LOW` stays in place until the last count of the period, which is a period boundary.

Every rising edge in `ST_BYPASS` counts as a period boundary. A new select value is picked up only at a period boundary, so a period that has started always completes with its old ratio.

Top module: `refclk_out_div`

## Requirements
- R1: While `rst_n` is low, the machine is held in `ST_BYPASS` and `clk_div` follows `clk_ref` exactly (ratio 1).
- R2: The select code sets the ratio as follows: 000→1, 001→2, 010→2, 011→3, 100→4, 101→5, 110→6, 111→8. `clk_div` has a period equal to the ratio times the period of `clk_ref`.
- R3: For even ratios, `clk_div` stays high for ratio/2 input periods. Its rising edge coincides with a rising edge of `clk_ref`.
- R4: For odd ratios 3 and 5, `clk_div` stays high for ratio/2 input periods (that is, ratio input half-periods). It rises on a rising edge of `clk_ref` and falls on a falling edge.
- R5: With code 000, `clk_div` equals `clk_ref`: high 1/2 period, period of 1 input period.
- R6: A change of `div_sel` takes effect only at the next period boundary. The period in progress completes with the old ratio, and the first new period starts on a rising edge of `clk_ref`.
- R7: Switching into or out of bypass completes the divided period in progress. The first pulse after the switch has the full width of its new ratio.
- R8: `stby` has no effect on `clk_div`.
- R9: The internal period counter stays below the active ratio, and the state register is always one-hot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Crystal reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_sel | input | 3 | Divide-ratio select code |
| stby | input | 1 | Device standby flag (does not stop the divider) |
| clk_div | output | 1 | Divided reference output clock, 50% duty |

## Verification
The bench times the edges of `clk_div` for every select code. An odd-ratio design that used only rising edges would show a high time one half-period short. A mapping error, such as code 010 or 110 decoding wrongly, would show up as a wrong period. Select changes are made in the middle of a long period and in and out of bypass. A divider that reloaded the ratio at once would cut the current pulse into a runt. A bypass mux that switched at the wrong moment would shorten the first pulse. `stby` is raised while the output is timed, so a design that gated the divider with it would lose its edges.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

    localparam int SEL_W   = 3;
    localparam int RATIO_W = 4;

    // One-hot state register; bit positions are used as glitch-free outputs.
    localparam int BYP_BIT = 0;
    localparam int HI_BIT  = 1;
    localparam int LO_BIT  = 2;

    typedef enum logic [2:0] {
        ST_BYPASS = 3'b001,
        ST_HIGH   = 3'b010,
        ST_LOW    = 3'b100
    } div_state_e;

endpackage

// File: rtl/refdiv_decode.sv
module refdiv_decode #(
    parameter int SEL_W = refdiv_pkg::SEL_W,
    parameter int RW    = refdiv_pkg::RATIO_W
) (
    input  logic [SEL_W-1:0] sel,
    output logic [RW-1:0]    ratio
);

    // Non-binary code map; 010 is unused and folds onto divide-by-2.
    always_comb begin
        case (sel)
            3'b000:  ratio = RW'(1);
            3'b001:  ratio = RW'(2);
            3'b010:  ratio = RW'(2);
            3'b011:  ratio = RW'(3);
            3'b100:  ratio = RW'(4);
            3'b101:  ratio = RW'(5);
            3'b110:  ratio = RW'(6);
            default: ratio = RW'(8);
        endcase
    end

endmodule

// File: rtl/refdiv_fsm.sv
module refdiv_fsm
    import refdiv_pkg::*;
#(
    parameter int RW = refdiv_pkg::RATIO_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] req_ratio,
    output logic          bypass,
    output logic          q_pos,
    output logic          odd_en,
    output logic [2:0]    state_bits,
    output logic [RW-1:0] cnt,
    output logic [RW-1:0] ratio
);

    localparam logic [RW-1:0] ONE = RW'(1);

    div_state_e    state_q, state_d;
    logic [RW-1:0] cnt_q, cnt_d;
    logic [RW-1:0] ratio_q, ratio_d;
    logic [RW-1:0] half;
    logic [RW-1:0] cnt_inc;
    logic          boundary;

    assign half     = ratio_q >> 1;
    assign cnt_inc  = cnt_q + ONE;
    assign boundary = (state_q == ST_BYPASS) ||
                      ((state_q == ST_LOW) && (cnt_q == ratio_q - ONE));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_BYPASS;
            cnt_q   <= '0;
            ratio_q <= ONE;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            ratio_q <= ratio_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_inc;
        ratio_d = ratio_q;
        unique case (state_q)
            ST_BYPASS: cnt_d = '0;
            ST_HIGH: begin
                if (cnt_inc == half) state_d = ST_LOW;   // end-high
            end
            ST_LOW: begin
                state_d = ST_LOW;                        // hold-low
            end
            default: state_d = ST_BYPASS;
        endcase
        if (boundary) begin
            ratio_d = req_ratio;
            cnt_d   = '0;
            state_d = (req_ratio == ONE) ? ST_BYPASS     // enter-bypass
                                         : ST_HIGH;      // start-period
        end
    end

    // Outputs taken from single state bits so no decode can glitch
    always_comb begin
        bypass     = state_q[BYP_BIT];
        q_pos      = state_q[HI_BIT];
        odd_en     = ratio_q[0];
        state_bits = state_q;
        cnt        = cnt_q;
        ratio      = ratio_q;
    end

endmodule

// File: rtl/refdiv_negretime.sv
module refdiv_negretime (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= d;
    end

endmodule

// File: rtl/refclk_out_div.sv
module refclk_out_div
    import refdiv_pkg::*;
#(
    parameter int SEL_W   = refdiv_pkg::SEL_W,
    parameter int RATIO_W = refdiv_pkg::RATIO_W
) (
    input  logic             clk_ref,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] div_sel,
    input  logic             stby,
    output logic             clk_div
);

    logic [RATIO_W-1:0] req_ratio;
    logic               bypass;
    logic               q_pos;
    logic               q_neg;
    logic               odd_en;
    logic [2:0]         fsm_state;
    logic [RATIO_W-1:0] fsm_cnt;
    logic [RATIO_W-1:0] fsm_ratio;
    logic               div_phase;

    // The divider is kept alive in standby on purpose.
    logic unused_stby;
    assign unused_stby = stby;

    refdiv_decode #(.SEL_W(SEL_W), .RW(RATIO_W)) u_decode (
        .sel   (div_sel),
        .ratio (req_ratio)
    );

    refdiv_fsm #(.RW(RATIO_W)) u_fsm (
        .clk        (clk_ref),
        .rst_n      (rst_n),
        .req_ratio  (req_ratio),
        .bypass     (bypass),
        .q_pos      (q_pos),
        .odd_en     (odd_en),
        .state_bits (fsm_state),
        .cnt        (fsm_cnt),
        .ratio      (fsm_ratio)
    );

    refdiv_negretime u_neg (
        .clk   (clk_ref),
        .rst_n (rst_n),
        .d     (q_pos),
        .q     (q_neg)
    );

    // Odd ratios stretch the high phase by half an input period.
    assign div_phase = q_pos | (odd_en & q_neg);
    assign clk_div   = bypass ? clk_ref : div_phase;

endmodule

// File: rtl/refclk_out_div_chk.sv
module refclk_out_div_chk #(
    parameter int RW = refdiv_pkg::RATIO_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    state_bits,
    input logic [RW-1:0] cnt,
    input logic [RW-1:0] ratio,
    input logic          q_pos
);

    localparam logic [2:0] BYP = 3'b001;

    assert_state_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(state_bits));

    assert_cnt_below_ratio_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < ratio);

    assert_ratio_at_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio != $past(ratio)) |->
            (($past(state_bits) == BYP) || ($past(cnt) == $past(ratio) - RW'(1))));

    assert_bypass_is_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_bits == BYP) |-> (ratio == RW'(1)));

    assert_legal_ratio_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio != RW'(7)) && (ratio != RW'(0)) && (ratio <= RW'(8)));

    assert_rise_at_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q_pos) |-> (cnt == '0));

    assert_high_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q_pos) && (state_bits != BYP) |-> (cnt == (ratio >> 1)));

endmodule

bind refclk_out_div refclk_out_div_chk #(.RW(RATIO_W)) u_chk (
    .clk        (clk_ref),
    .rst_n      (rst_n),
    .state_bits (fsm_state),
    .cnt        (fsm_cnt),
    .ratio      (fsm_ratio),
    .q_pos      (q_pos)
);

// File: tb/refclk_out_div_bench.sv
`timescale 1ns/1ps
module refclk_out_div_bench;

    logic       clk_ref = 1'b0;
    logic       rst_n   = 1'b0;
    logic [2:0] div_sel = 3'b000;
    logic       stby    = 1'b0;
    logic       clk_div;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk_ref = ~clk_ref;

    refclk_out_div u_refclk_out_div (
        .clk_ref (clk_ref),
        .rst_n   (rst_n),
        .div_sel (div_sel),
        .stby    (stby),
        .clk_div (clk_div)
    );

    // {code, ratio}
    localparam logic [6:0] VEC [8] = '{
        {3'b000, 4'd1}, {3'b001, 4'd2}, {3'b010, 4'd2}, {3'b011, 4'd3},
        {3'b100, 4'd4}, {3'b101, 4'd5}, {3'b110, 4'd6}, {3'b111, 4'd8}
    };

    task automatic chk(input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic measure(output longint hi, output longint per);
        time t0, t1, t2;
        @(posedge clk_div); t0 = $time;
        @(negedge clk_div); t1 = $time;
        @(posedge clk_div); t2 = $time;
        hi  = longint'(t1 - t0);
        per = longint'(t2 - t0);
    endtask

    task automatic drive_sel(input logic [2:0] code);
        @(negedge clk_ref); #5;
        div_sel = code;
    endtask

    initial begin
        #2_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        longint hi, per;
        time t0, t1, t2, t3, t4;

        // R1: reset holds bypass, output follows reference
        div_sel = 3'b111;
        @(posedge clk_ref); #5;
        chk("R1", "reset high phase", clk_div, 1);
        @(negedge clk_ref); #5;
        chk("R1", "reset low phase", clk_div, 0);
        repeat (2) @(posedge clk_ref);
        drive_sel(3'b000);
        rst_n = 1'b1;

        // R2/R3/R4/R5: table walk over every code
        for (int i = 0; i < 8; i++) begin
            drive_sel(VEC[i][6:4]);
            repeat (24) @(posedge clk_ref);
            measure(hi, per);
            chk("R2", $sformatf("period code %b", VEC[i][6:4]), per, 20 * VEC[i][3:0]);
            chk(VEC[i][3:0] == 1 ? "R5" : (VEC[i][0] ? "R4" : "R3"),
                $sformatf("high code %b", VEC[i][6:4]), hi, 10 * VEC[i][3:0]);
        end

        // R8: standby raised while running divide-by-3
        drive_sel(3'b011);
        repeat (24) @(posedge clk_ref);
        stby = 1'b1;
        measure(hi, per);
        chk("R8", "standby period", per, 60);
        chk("R8", "standby high", hi, 30);
        stby = 1'b0;

        // R6: change from 8 to 3 in the middle of a period
        drive_sel(3'b111);
        repeat (24) @(posedge clk_ref);
        @(posedge clk_div); t0 = $time;
        #25 div_sel = 3'b011;
        @(negedge clk_div); t1 = $time;
        @(posedge clk_div); t2 = $time;
        @(negedge clk_div); t3 = $time;
        @(posedge clk_div); t4 = $time;
        chk("R6", "old high kept", longint'(t1 - t0), 80);
        chk("R6", "old period kept", longint'(t2 - t0), 160);
        chk("R6", "new high", longint'(t3 - t2), 30);
        chk("R6", "new period", longint'(t4 - t2), 60);

        // R7: leave bypass into divide-by-5
        drive_sel(3'b000);
        repeat (24) @(posedge clk_ref);
        drive_sel(3'b101);
        @(posedge clk_div); t0 = $time;
        @(negedge clk_div); t1 = $time;
        @(posedge clk_div); t2 = $time;
        chk("R7", "first high after bypass exit", longint'(t1 - t0), 50);
        chk("R7", "first period after bypass exit", longint'(t2 - t0), 100);

        // R7: enter bypass from divide-by-5 mid-period
        repeat (12) @(posedge clk_ref);
        @(posedge clk_div); t0 = $time;
        #25 div_sel = 3'b000;
        @(negedge clk_div); t1 = $time;
        @(posedge clk_div); t2 = $time;
        chk("R7", "last divided high", longint'(t1 - t0), 50);
        chk("R7", "last divided period", longint'(t2 - t0), 100);
        measure(hi, per);
        chk("R7", "bypass high after entry", hi, 10);
        chk("R7", "bypass period after entry", per, 20);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule